// File: doc/BRIEF.md
# Global-History Selected Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. Each counter is chosen by a few low address bits of the branch joined to a short global history of recent outcomes. The front end presents a branch address on the lookup side each cycle and gets a taken or not-taken guess back combinationally. In this model the front end already knows the real outcome at fetch, so it also presents that outcome, and the block flags a wrong guess at once.

Resolved branches come back on one or more update lanes. Each lane carries the branch address, the real outcome and the branch's sequence tag. Lanes that arrive in the same cycle are applied one after another in ascending tag order. Each lane trains the counter selected by the history as it stood before that lane, then shifts its outcome into the history.

A wrong guess records the branch's tag in a small queue and raises a dispatch-stall output. The stall stays high until an update lane returns that tag, and it falls in the cycle after. The fetch side is never held.

Top module: `gselect_predictor`

## Requirements
- R1: After reset every counter holds weakly-not-taken (value 1), the history is zero and `dispatch_stall` is low, so every address predicts not-taken.
- R2: The counter index is {address bits [5:2], history[2:0]}. Address bits outside [5:2] have no effect on which counter is read or trained.
- R3: `lk_pred` is the counter's upper bit (taken when the counter is 2 or 3). It follows `lk_addr` in the same cycle and reads the state as it was before any update made in that cycle.
- R4: A taken update increments the selected counter and a not-taken update decrements it, saturating at 3 and at 0.
- R5: Each applied update trains the counter indexed with the history before that update, then shifts the history left by one and puts the outcome (1 = taken) in bit 0.
- R6: Several valid lanes in one cycle are applied in ascending tag order, with the lower lane number first on equal tags. Each lane sees the history and counters left by the lanes before it.
- R7: `lk_mispred` is high exactly when `lk_valid` is high and `lk_pred` differs from `lk_taken`.
- R8: `dispatch_stall` is high in the cycle after a mispredicted lookup.
- R9: `dispatch_stall` stays high while a mispredicted tag is outstanding, and falls in the cycle after a valid update lane carries that tag.
- R10: Up to 4 mispredicted tags are held in lookup order. Only the oldest can be retired, an update matching a younger tag leaves the queue unchanged, and the stall holds until the queue is empty. The caller keeps no more than 4 outstanding.
- R11: Update lanes whose valid bit is low change neither the counters nor the history.
- R12: A lookup with `lk_valid` low never raises `lk_mispred` and never queues a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A branch is presented for prediction |
| lk_addr | input | 32 | Address of the branch being predicted |
| lk_tag | input | 8 | Sequence tag of the branch being predicted |
| lk_taken | input | 1 | Real outcome of that branch, 1 = taken |
| lk_pred | output | 1 | Guess, 1 = taken |
| lk_mispred | output | 1 | Guess differs from the real outcome |
| up_valid | input | 2 | Per-lane update valid |
| up_addr | input | 64 | Per-lane branch address, lane 0 in the low word |
| up_tag | input | 16 | Per-lane branch tag, lane 0 in the low byte |
| up_taken | input | 2 | Per-lane real outcome |
| dispatch_stall | output | 1 | Hold dispatch; a mispredicted branch is outstanding |

## Verification
The counters are first read across all sixteen address slots at reset. They are then read again after runs of training on one address. These runs separate index aliasing, saturation at both ends and the shifting of history. Two-lane cycles are sent with the tags in both orders, so that a predictor ignoring tag order ends up with a different history. Mispredicted lookups are queued two deep and retired both out of order and in order, which shows whether only the oldest tag releases the stall. A long random sweep then mixes lookups, paired updates and tag retirements against an arithmetic model of the counters, history and queue.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'd0,
      CTR_WEAK_NT   = 2'd1,
      CTR_WEAK_T    = 2'd2,
      CTR_STRONG_T  = 2'd3
   } ctr_state_e;

   // Saturating two-bit step toward the observed outcome.
   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic taken);
      logic [1:0] nxt;
      if (taken) nxt = (cur == 2'd3) ? cur : cur + 2'd1;
      else       nxt = (cur == 2'd0) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input logic [1:0] cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/gsp_tag_order.sv
module gsp_tag_order #(
   parameter int N     = 2,
   parameter int TAG_W = 8,
   parameter int LW    = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]       lane_valid,
   input  logic [N*TAG_W-1:0] lane_tag,
   output logic [N-1:0]       slot_valid,
   output logic [N*LW-1:0]    slot_lane
);

   generate
      if (N == 1) begin : g_single
         assign slot_valid = lane_valid;
         assign slot_lane  = '0;
      end else begin : g_sort
         localparam int RW = $clog2(N + 1);
         logic [RW-1:0] rank [N];

         // Rank of each valid lane = number of valid lanes that go before it.
         always_comb begin
            for (int i = 0; i < N; i++) begin
               rank[i] = '0;
               for (int j = 0; j < N; j++) begin
                  if (j != i && lane_valid[j] &&
                      ((lane_tag[j*TAG_W +: TAG_W] < lane_tag[i*TAG_W +: TAG_W]) ||
                       ((lane_tag[j*TAG_W +: TAG_W] == lane_tag[i*TAG_W +: TAG_W]) && (j < i))))
                     rank[i] = rank[i] + RW'(1);
               end
            end
         end

         always_comb begin
            slot_valid = '0;
            slot_lane  = '0;
            for (int r = 0; r < N; r++) begin
               for (int i = 0; i < N; i++) begin
                  if (lane_valid[i] && (rank[i] == RW'(r))) begin
                     slot_valid[r]            = 1'b1;
                     slot_lane[r*LW +: LW]    = LW'(i);
                  end
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gsp_update_chain.sv
module gsp_update_chain
   import gsp_pkg::*;
#(
   parameter int N        = 2,
   parameter int ADDR_W   = 32,
   parameter int HIST_W   = 3,
   parameter int PC_IDX_W = 4,
   parameter int PC_LSB   = 2,
   parameter int IDX_W    = PC_IDX_W + HIST_W,
   parameter int ENTRIES  = 1 << IDX_W
) (
   input  logic [HIST_W-1:0]          ghr_cur,
   input  logic [ENTRIES-1:0][1:0]    tbl_cur,
   input  logic [N-1:0]               slot_valid,
   input  logic [N*ADDR_W-1:0]        slot_addr,
   input  logic [N-1:0]               slot_taken,
   output logic [HIST_W-1:0]          ghr_nxt,
   output logic [ENTRIES-1:0][1:0]    tbl_nxt
);

   logic [HIST_W-1:0] ghr_w;
   logic [IDX_W-1:0]  idx;

   // Slots are already in tag order; each one sees the effect of the ones before.
   always_comb begin
      ghr_w   = ghr_cur;
      tbl_nxt = tbl_cur;
      idx     = '0;
      for (int r = 0; r < N; r++) begin
         if (slot_valid[r]) begin
            idx          = {slot_addr[r*ADDR_W + PC_LSB +: PC_IDX_W], ghr_w};
            tbl_nxt[idx] = ctr_step(tbl_nxt[idx], slot_taken[r]);
            ghr_w        = HIST_W'({ghr_w, slot_taken[r]});
         end
      end
      ghr_nxt = ghr_w;
   end

endmodule

// File: rtl/gsp_pending_q.sv
module gsp_pending_q #(
   parameter int DEPTH = 4,
   parameter int TAG_W = 8,
   parameter int N     = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [TAG_W-1:0]   push_tag,
   input  logic [N-1:0]       up_valid,
   input  logic [N*TAG_W-1:0] up_tag,
   output logic               busy
);

   logic             head_v;
   logic [TAG_W-1:0] head_tag;
   logic             full;
   logic             hit;
   logic             pop;

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < N; i++)
         if (up_valid[i] && (up_tag[i*TAG_W +: TAG_W] == head_tag)) hit = 1'b1;
   end

   assign pop  = head_v & hit;
   assign busy = head_v;

   generate
      if (DEPTH == 1) begin : g_reg
         logic             held_v;
         logic [TAG_W-1:0] held_tag;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               held_v   <= 1'b0;
               held_tag <= '0;
            end else if (pop || !held_v) begin
               held_v   <= push;
               held_tag <= push_tag;
            end
         end

         assign head_v   = held_v;
         assign head_tag = held_tag;
         assign full     = held_v;
      end else begin : g_fifo
         localparam int PW = $clog2(DEPTH);
         localparam int CW = PW + 1;

         if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
            $error("gsp_pending_q: DEPTH must be a power of two");
         end

         logic [TAG_W-1:0] mem [DEPTH];
         logic [PW-1:0]    rd_ptr, wr_ptr;
         logic [CW-1:0]    cnt;
         logic             do_push;

         assign head_v   = (cnt != '0);
         assign head_tag = mem[rd_ptr];
         assign full     = (cnt == CW'(DEPTH));
         assign do_push  = push && (!full || pop);

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= push_tag;
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_ptr <= '0;
               wr_ptr <= '0;
               cnt    <= '0;
            end else begin
               if (do_push) wr_ptr <= wr_ptr + PW'(1);
               if (pop)     rd_ptr <= rd_ptr + PW'(1);
               cnt <= cnt + CW'(do_push) - CW'(pop);
            end
         end
      end
   endgenerate

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full && !pop)); // R10

   AST_RETIRE_DROPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && (DEPTH == 1)) |=> !busy); // R9

endmodule

// File: rtl/gselect_predictor.sv
module gselect_predictor
   import gsp_pkg::*;
#(
   parameter int         ADDR_W     = 32,
   parameter int         TAG_W      = 8,
   parameter int         N_UPD      = 2,
   parameter int         HIST_W     = 3,
   parameter int         PC_IDX_W   = 4,
   parameter int         PC_LSB     = 2,
   parameter int         PEND_DEPTH = 4,
   parameter ctr_state_e CTR_INIT   = CTR_WEAK_NT
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [ADDR_W-1:0]        lk_addr,
   input  logic [TAG_W-1:0]         lk_tag,
   input  logic                     lk_taken,
   output logic                     lk_pred,
   output logic                     lk_mispred,
   input  logic [N_UPD-1:0]         up_valid,
   input  logic [N_UPD*ADDR_W-1:0]  up_addr,
   input  logic [N_UPD*TAG_W-1:0]   up_tag,
   input  logic [N_UPD-1:0]         up_taken,
   output logic                     dispatch_stall
);

   localparam int         IDX_W     = PC_IDX_W + HIST_W;
   localparam int         ENTRIES   = 1 << IDX_W;
   localparam int         LW        = (N_UPD > 1) ? $clog2(N_UPD) : 1;
   localparam logic [1:0] INIT_BITS = CTR_INIT;

   // Elaboration-time parameter checks.
   generate
      if (PC_LSB + PC_IDX_W > ADDR_W) begin : g_bad_addr
         $error("gselect_predictor: address slice exceeds ADDR_W");
      end
      if (HIST_W < 1 || PC_IDX_W < 1) begin : g_bad_idx
         $error("gselect_predictor: index fields must be at least one bit");
      end
      if (IDX_W > 12) begin : g_bad_size
         $error("gselect_predictor: table larger than 4096 counters");
      end
      if (N_UPD < 1 || PEND_DEPTH < 1) begin : g_bad_count
         $error("gselect_predictor: lane count and queue depth must be positive");
      end
   endgenerate

   logic [ENTRIES-1:0][1:0] ctr_q, ctr_d;
   logic [HIST_W-1:0]       ghr_q, ghr_d;

   // Lookup side: reads registered state only.
   logic [IDX_W-1:0] lk_idx;
   assign lk_idx     = {lk_addr[PC_LSB +: PC_IDX_W], ghr_q};
   assign lk_pred    = ctr_says_taken(ctr_q[lk_idx]);
   assign lk_mispred = lk_valid && (lk_pred != lk_taken);

   // Update side: order lanes by tag, then apply serially.
   logic [N_UPD-1:0]        slot_valid;
   logic [N_UPD*LW-1:0]     slot_lane;
   logic [N_UPD*ADDR_W-1:0] slot_addr;
   logic [N_UPD-1:0]        slot_taken;
   logic [LW-1:0]           lane;

   gsp_tag_order #(
      .N     (N_UPD),
      .TAG_W (TAG_W),
      .LW    (LW)
   ) u_order (
      .lane_valid (up_valid),
      .lane_tag   (up_tag),
      .slot_valid (slot_valid),
      .slot_lane  (slot_lane)
   );

   always_comb begin
      slot_addr  = '0;
      slot_taken = '0;
      lane       = '0;
      for (int r = 0; r < N_UPD; r++) begin
         lane                          = slot_lane[r*LW +: LW];
         slot_addr[r*ADDR_W +: ADDR_W] = up_addr[int'(lane)*ADDR_W +: ADDR_W];
         slot_taken[r]                 = up_taken[int'(lane)];
      end
   end

   gsp_update_chain #(
      .N        (N_UPD),
      .ADDR_W   (ADDR_W),
      .HIST_W   (HIST_W),
      .PC_IDX_W (PC_IDX_W),
      .PC_LSB   (PC_LSB),
      .IDX_W    (IDX_W),
      .ENTRIES  (ENTRIES)
   ) u_chain (
      .ghr_cur    (ghr_q),
      .tbl_cur    (ctr_q),
      .slot_valid (slot_valid),
      .slot_addr  (slot_addr),
      .slot_taken (slot_taken),
      .ghr_nxt    (ghr_d),
      .tbl_nxt    (ctr_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr_q <= {ENTRIES{INIT_BITS}};
         ghr_q <= '0;
      end else begin
         ctr_q <= ctr_d;
         ghr_q <= ghr_d;
      end
   end

   gsp_pending_q #(
      .DEPTH (PEND_DEPTH),
      .TAG_W (TAG_W),
      .N     (N_UPD)
   ) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (lk_mispred),
      .push_tag (lk_tag),
      .up_valid (up_valid),
      .up_tag   (up_tag),
      .busy     (dispatch_stall)
   );

   AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_mispred |=> dispatch_stall); // R8

   AST_STALL_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dispatch_stall) |-> $past(lk_valid && lk_mispred)); // R8

   AST_STALL_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dispatch_stall) |-> $past(|up_valid)); // R9

   AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|up_valid) |=> ($stable(ghr_q) && $stable(ctr_q))); // R11

   AST_HISTORY_TAKES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(up_valid) == 1) |=> (ghr_q[0] == $past(|(up_valid & up_taken)))); // R5

endmodule

// File: tb/gselect_predictor_tb.sv
module gselect_predictor_tb;

   localparam int AW = 32;
   localparam int TW = 8;
   localparam int NU = 2;
   localparam int PD = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            lk_valid, lk_taken, lk_pred, lk_mispred, dispatch_stall;
   logic [AW-1:0]   lk_addr;
   logic [TW-1:0]   lk_tag;
   logic [NU-1:0]   up_valid, up_taken;
   logic [NU*AW-1:0] up_addr;
   logic [NU*TW-1:0] up_tag;

   always #4 clk = ~clk;

   gselect_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_tag(lk_tag), .lk_taken(lk_taken),
      .lk_pred(lk_pred), .lk_mispred(lk_mispred),
      .up_valid(up_valid), .up_addr(up_addr), .up_tag(up_tag), .up_taken(up_taken),
      .dispatch_stall(dispatch_stall)
   );

   // Arithmetic model of the requirements.
   logic [1:0]    m_ctr [128];
   logic [2:0]    m_ghr;
   logic [TW-1:0] m_q [PD];
   int            m_cnt;
   int            checks = 0;
   int            errors = 0;
   string         req = "R1";
   bit            done = 1'b0;
   logic [TW-1:0] nt = '0;

   function automatic logic m_pred(input logic [AW-1:0] a);
      return m_ctr[{a[5:2], m_ghr}][1];
   endfunction

   task automatic m_upd(input logic [AW-1:0] a, input logic t);
      logic [6:0] ix;
      ix = {a[5:2], m_ghr};
      if (t && m_ctr[ix] != 2'd3) m_ctr[ix] = m_ctr[ix] + 2'd1;
      else if (!t && m_ctr[ix] != 2'd0) m_ctr[ix] = m_ctr[ix] - 2'd1;
      m_ghr = {m_ghr[1:0], t};
   endtask

   task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   // One cycle, entered and left at a falling edge.
   task automatic cyc(input logic lv, input logic [AW-1:0] la, input logic [TW-1:0] lg, input logic lt,
                      input logic v0, input logic [AW-1:0] a0, input logic [TW-1:0] g0, input logic k0,
                      input logic v1, input logic [AW-1:0] a1, input logic [TW-1:0] g1, input logic k1);
      logic p;
      chk(32'(dispatch_stall), 32'(m_cnt != 0), "dispatch_stall");
      lk_valid = lv; lk_addr = la; lk_tag = lg; lk_taken = lt;
      up_valid = {v1, v0}; up_addr = {a1, a0}; up_tag = {g1, g0}; up_taken = {k1, k0};
      #1;
      p = m_pred(la);
      chk(32'(lk_pred), 32'(p), "lk_pred");
      chk(32'(lk_mispred), 32'(lv && (p != lt)), "lk_mispred");
      if (m_cnt > 0 && ((v0 && g0 == m_q[0]) || (v1 && g1 == m_q[0]))) begin
         for (int k = 0; k < PD - 1; k++) m_q[k] = m_q[k+1];
         m_cnt--;
      end
      if (lv && (p != lt) && m_cnt < PD) begin
         m_q[m_cnt] = lg;
         m_cnt++;
      end
      if (v0 && v1 && (g1 < g0)) begin
         m_upd(a1, k1); m_upd(a0, k0);
      end else begin
         if (v0) m_upd(a0, k0);
         if (v1) m_upd(a1, k1);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic look(input logic [AW-1:0] a);
      cyc(1'b0, a, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0);
   endtask

   task automatic upd(input logic [AW-1:0] a, input logic t);
      cyc(1'b0, a, 8'd0, 1'b0, 1'b1, a, nt, t, 1'b0, '0, 8'd0, 1'b0);
      nt = nt + 8'd1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic lt1, lt2;
      lk_valid = 0; lk_addr = '0; lk_tag = '0; lk_taken = 0;
      up_valid = '0; up_addr = '0; up_tag = '0; up_taken = '0;
      for (int i = 0; i < 128; i++) m_ctr[i] = 2'd1;
      m_ghr = '0; m_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      req = "R1";   // reset: every slot not-taken, no stall
      for (int a = 0; a < 16; a++) look(32'(a) << 2);

      req = "R2";   // only bits [5:2] select
      for (int k = 0; k < 8; k++) upd(32'h10 + 32'(k) * 32'h40, 1'b1);
      for (int k = 0; k < 4; k++) look(32'h10 + 32'(k) * 32'h40 + 32'h3);
      look(32'h14); look(32'h50); look(32'hFFFF_FF90);

      req = "R4";   // saturation both ways
      repeat (6) upd(32'h20, 1'b1);
      repeat (2) look(32'h20);
      repeat (8) upd(32'h24, 1'b0);
      look(32'h24); look(32'h20);

      req = "R5";   // history shifting
      for (int i = 0; i < 12; i++) begin
         upd(32'h0, (i % 3) == 0);
         look(32'h0); look(32'h3c);
      end

      req = "R3";
      for (int a = 0; a < 16; a++) look(32'(a) << 2);

      req = "R6";   // same-cycle ordering by tag
      repeat (4) upd(32'h8, 1'b1);
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h8, 8'd60, 1'b1, 1'b1, 32'hC, 8'd20, 1'b0);
      for (int a = 0; a < 16; a++) look(32'(a) << 2);
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h8, 8'd30, 1'b0, 1'b1, 32'hC, 8'd70, 1'b1);
      for (int a = 0; a < 16; a++) look(32'(a) << 2);

      req = "R7";
      lt1 = !m_pred(32'h40);
      cyc(1'b1, 32'h40, 8'd200, lt1, 1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0);
      req = "R8";
      repeat (3) look(32'h40);
      req = "R9";
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h40, 8'd200, lt1);
      look(32'h40); look(32'h40);

      req = "R10";  // two outstanding, younger retire has no effect
      lt1 = !m_pred(32'h44);
      cyc(1'b1, 32'h44, 8'd210, lt1, 1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0);
      lt2 = !m_pred(32'h48);
      cyc(1'b1, 32'h48, 8'd211, lt2, 1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0);
      look(32'h0);
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h48, 8'd211, lt2, 1'b0, '0, 8'd0, 1'b0);
      look(32'h0);
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h44, 8'd210, lt1);
      look(32'h0);
      cyc(1'b0, '0, 8'd0, 1'b0, 1'b1, 32'h48, 8'd211, lt2, 1'b0, '0, 8'd0, 1'b0);
      look(32'h0); look(32'h0);

      req = "R11";  // invalid lanes ignored
      repeat (5) cyc(1'b0, '0, 8'd0, 1'b0, 1'b0, 32'hFFFF_FFFC, 8'd5, 1'b1, 1'b0, 32'h1234, 8'd6, 1'b1);
      for (int a = 0; a < 16; a++) look(32'(a) << 2);

      req = "R12";  // invalid lookup never flags or stalls
      repeat (4) cyc(1'b0, 32'h4c, 8'd99, !m_pred(32'h4c), 1'b0, '0, 8'd0, 1'b0, 1'b0, '0, 8'd0, 1'b0);
      look(32'h4c);

      req = "R3";   // random sweep against the model
      repeat (3000) begin
         logic lv, lt, v0, v1, k0, k1;
         logic [AW-1:0] la, a0, a1;
         logic [TW-1:0] g0, g1;
         lv = ($urandom % 2 == 1) && (m_cnt < PD);
         la = $urandom & 32'hFF;
         lt = 1'($urandom % 2);
         v0 = 1'($urandom % 2); a0 = $urandom; k0 = 1'($urandom % 2);
         v1 = 1'($urandom % 2); a1 = $urandom; k1 = 1'($urandom % 2);
         g0 = (m_cnt > 0 && ($urandom % 3 == 0)) ? m_q[0] : TW'($urandom);
         g1 = TW'($urandom);
         cyc(lv, la, nt, lt, v0, a0, g0, k0, v1, a1, g1, k1);
         nt = nt + 8'd1;
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule